// File: doc/BRIEF.md
# Weighted Scan Transition Metric Calculator

This block scores scan test patterns by how much switching they cause while being shifted. Each L-bit pattern enters on a valid/ready stream, one per cycle at most. For every pair of neighbouring bits that differ, the block adds a weight that falls off with the pair's distance from the scan-input side: the pair at (j, j+1) counts L − j. Bit 0 is the first bit shifted in. The sum over all pairs is the pattern's metric.

Over a window of patterns the block keeps the largest metric seen, the running total and the pattern count. A window opens with a start pulse. An end pulse launches a sequential restoring divide of the total by the count, and a one-cycle done strobe marks the result. Stream rules: a pattern is taken on any rising edge where both in_valid and in_ready are high. in_ready drops in the cycle win_end is raised and stays low until the done strobe, so upstream must hold its pattern through that time. The metric output has no back-pressure and is valid for the single cycle marked by metric_valid.

Top module: `wtm_calc`

## Requirements
- R1: After reset, in_ready is 1 and metric_valid, done, metric, peak, total and average are all 0.
- R2: The metric of pattern p equals the sum over j = 0 to L−2 of (L − j)·(p[j] XOR p[j+1]), where p[0] is the first bit shifted in.
- R3: metric and metric_valid appear in the cycle after the edge that takes the pattern. metric_valid stays low in cycles after edges where no pattern was taken.
- R4: in_ready is low while win_end is high and from the edge that samples win_end until the done strobe. While in_ready is low, in_valid has no effect, and no metric_valid follows.
- R5: peak equals the largest metric accepted since the last window start. It is updated one edge after metric_valid.
- R6: total equals the sum of the metrics accepted since the last window start. It is updated one edge after metric_valid.
- R7: A win_start sampled while idle clears peak, total and count. The clear wins over a metric that is being folded in on the same edge. A win_start sampled during the divide is ignored.
- R8: For a non-empty window, done pulses for one cycle, exactly TW+1 edges after the edge that samples win_end, with TW = MW + CNT_W. At that point average = floor(total / count), and average holds until the next done.
- R9: For an empty window, done pulses one edge after the edge that samples win_end, and average is 0.
- R10: At every done strobe, average is no greater than peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pattern present on in_pattern |
| in_ready | output | 1 | Block can take a pattern this cycle |
| in_pattern | input | SCAN_LEN | Scan pattern, bit 0 shifted in first |
| win_start | input | 1 | Opens a new window (clears peak, total, count) |
| win_end | input | 1 | Closes the window and starts the divide |
| metric | output | MW | Weighted transition metric of the last accepted pattern |
| metric_valid | output | 1 | metric is fresh this cycle |
| peak | output | MW | Largest metric in the window |
| total | output | TW | Sum of metrics in the window |
| average | output | MW | Quotient total / count from the last divide |
| done | output | 1 | One-cycle strobe: average is updated |

## Verification
The metric is due one edge after acceptance, and peak and total are due one edge after that. The bench drives inputs on falling edges and reads results on the next falling edge, counting each register in between. After win_end, the bench counts rising edges until done and compares the count with TW+1, or with 1 for an empty window. It reads average, peak and total only at that strobe and one cycle later. A window start and pattern offers injected during the divide are checked for having no effect on peak, total or metric_valid.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  typedef enum logic [1:0] {
    DV_IDLE,
    DV_LOAD,
    DV_STEP
  } dv_state_t;

  // Largest possible metric: weights 2..L summed.
  function automatic int metric_max(input int len);
    return (len * (len + 1)) / 2 - 1;
  endfunction

endpackage

// File: rtl/wtm_metric.sv
module wtm_metric #(
  parameter int L    = 32,
  parameter int MW   = 10,
  parameter int MAXM = 527
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [L-1:0]  pattern,
  output logic [MW-1:0] metric,
  output logic          metric_valid
);

  logic [MW-1:0] term [L-1];
  logic [MW-1:0] sum;

  for (genvar j = 0; j < L - 1; j++) begin : g_pair
    assign term[j] = (pattern[j] ^ pattern[j+1]) ? MW'(L - j) : '0;
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < L - 1; j++) sum = sum + term[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metric       <= '0;
      metric_valid <= 1'b0;
    end else begin
      metric_valid <= take;
      if (take) metric <= sum;
    end
  end

  p_metric_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> (int'(metric) <= MAXM));

endmodule

// File: rtl/wtm_window_acc.sv
module wtm_window_acc #(
  parameter int MW    = 10,
  parameter int CNT_W = 16,
  parameter int TW    = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mvalid,
  input  logic [MW-1:0]    metric,
  output logic [MW-1:0]    peak,
  output logic [TW-1:0]    total,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak  <= '0;
      total <= '0;
      count <= '0;
    end else if (clr) begin
      peak  <= '0;
      total <= '0;
      count <= '0;
    end else if (mvalid) begin
      total <= total + TW'(metric);
      count <= count + 1'b1;
      if (metric > peak) peak <= metric;
    end
  end

  p_peak_covers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mvalid && !clr) |=> (peak >= $past(metric)));

  p_total_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mvalid && !clr) |=> (total >= TW'($past(metric))));

endmodule

// File: rtl/wtm_divider.sv
module wtm_divider
  import wtm_pkg::*;
#(
  parameter int MW    = 10,
  parameter int CNT_W = 16,
  parameter int TW    = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TW-1:0]    dividend,
  input  logic [CNT_W-1:0] divisor,
  output logic             busy,
  output logic [MW-1:0]    quotient,
  output logic             done
);

  localparam int IW = $clog2(TW + 1);

  dv_state_t        state;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] dvs;
  logic [TW-1:0]    quo;
  logic [TW-1:0]    result;
  logic [IW-1:0]    iter;

  logic [CNT_W:0]   shifted;
  logic             qbit;
  logic [CNT_W:0]   diff;
  logic [TW-1:0]    quo_next;

  always_comb begin
    shifted  = {rem, quo[TW-1]};
    qbit     = (shifted >= {1'b0, dvs});
    diff     = shifted - {1'b0, dvs};
    quo_next = {quo[TW-2:0], qbit};
  end

  assign busy     = (state != DV_IDLE);
  assign quotient = result[MW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= DV_IDLE;
      rem    <= '0;
      dvs    <= '0;
      quo    <= '0;
      result <= '0;
      iter   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        DV_IDLE: if (start) state <= DV_LOAD;
        DV_LOAD: begin
          if (divisor == '0) begin
            result <= '0;
            done   <= 1'b1;
            state  <= DV_IDLE;
          end else begin
            rem   <= '0;
            dvs   <= divisor;
            quo   <= dividend;
            iter  <= '0;
            state <= DV_STEP;
          end
        end
        DV_STEP: begin
          rem  <= qbit ? diff[CNT_W-1:0] : shifted[CNT_W-1:0];
          quo  <= quo_next;
          iter <= iter + 1'b1;
          if (iter == IW'(TW - 1)) begin
            result <= quo_next;
            done   <= 1'b1;
            state  <= DV_IDLE;
          end
        end
        default: state <= DV_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quot_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[TW-1:MW] == '0));

endmodule

// File: rtl/wtm_calc.sv
module wtm_calc #(
  parameter  int SCAN_LEN = 32,
  parameter  int CNT_W    = 16,
  localparam int MAXM     = wtm_pkg::metric_max(SCAN_LEN),
  localparam int MW       = $clog2(MAXM + 1),
  localparam int TW       = MW + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SCAN_LEN-1:0] in_pattern,
  input  logic                win_start,
  input  logic                win_end,
  output logic [MW-1:0]       metric,
  output logic                metric_valid,
  output logic [MW-1:0]       peak,
  output logic [TW-1:0]       total,
  output logic [MW-1:0]       average,
  output logic                done
);

  logic             busy;
  logic             take;
  logic             clr;
  logic [CNT_W-1:0] count;

  assign in_ready = !busy && !win_end;
  assign take     = in_valid && in_ready;
  assign clr      = win_start && !busy;

  wtm_metric #(.L(SCAN_LEN), .MW(MW), .MAXM(MAXM)) u_metric (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .pattern      (in_pattern),
    .metric       (metric),
    .metric_valid (metric_valid)
  );

  wtm_window_acc #(.MW(MW), .CNT_W(CNT_W), .TW(TW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .mvalid (metric_valid),
    .metric (metric),
    .peak   (peak),
    .total  (total),
    .count  (count)
  );

  wtm_divider #(.MW(MW), .CNT_W(CNT_W), .TW(TW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (win_end && !busy),
    .dividend (total),
    .divisor  (count),
    .busy     (busy),
    .quotient (average),
    .done     (done)
  );

  p_metric_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> $past(in_valid && in_ready));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(total));

  p_avg_le_peak_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (average <= peak));

endmodule

// File: tb/wtm_calc_tb.sv
module wtm_calc_tb;

  localparam int L     = 6;
  localparam int CNT_W = 4;
  localparam int MAXM  = L * (L + 1) / 2 - 1;
  localparam int MW    = $clog2(MAXM + 1);
  localparam int TW    = MW + CNT_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [L-1:0]  in_pattern;
  logic          win_start;
  logic          win_end;
  logic [MW-1:0] metric;
  logic          metric_valid;
  logic [MW-1:0] peak;
  logic [TW-1:0] total;
  logic [MW-1:0] average;
  logic          done;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  wtm_calc #(.SCAN_LEN(L), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pattern(in_pattern), .win_start(win_start), .win_end(win_end),
    .metric(metric), .metric_valid(metric_valid), .peak(peak),
    .total(total), .average(average), .done(done)
  );

  function automatic int ref_metric(input int p);
    int s = 0;
    for (int j = 0; j < L - 1; j++)
      if (((p >> j) & 1) != ((p >> (j + 1)) & 1)) s += L - j;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  int e_peak, e_total, e_cnt;

  task automatic send(input int p);
    int m;
    m = ref_metric(p);
    in_valid   = 1'b1;
    in_pattern = L'(p);
    cyc();
    in_valid = 1'b0;
    chk(metric_valid == 1'b1, "R3 metric_valid", int'(metric_valid), 1);
    chk(int'(metric) == m, "R2 metric", int'(metric), m);
    e_total += m;
    e_cnt++;
    if (m > e_peak) e_peak = m;
  endtask

  task automatic open_window();
    win_start = 1'b1;
    cyc();
    win_start = 1'b0;
    e_peak = 0; e_total = 0; e_cnt = 0;
    chk(peak == '0, "R7 peak cleared", int'(peak), 0);
    chk(total == '0, "R7 total cleared", int'(total), 0);
  endtask

  task automatic close_window();
    int edges;
    int exp_avg;
    win_end = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R4 ready low with win_end", int'(in_ready), 0);
    cyc();
    win_end = 1'b0;
    edges = 1;
    // intrusions during the divide: both must be ignored
    win_start  = 1'b1;
    in_valid   = 1'b1;
    in_pattern = L'(21);
    #1;
    if (!done)
      chk(in_ready == 1'b0, "R4 ready low while dividing", int'(in_ready), 0);
    while (!done && edges < 100) begin
      cyc();
      win_start = 1'b0;
      in_valid  = 1'b0;
      if (!done)
        chk(metric_valid == 1'b0, "R4 no metric while busy", int'(metric_valid), 0);
      if (!done) edges++;
    end
    win_start = 1'b0;
    in_valid  = 1'b0;
    exp_avg = (e_cnt == 0) ? 0 : e_total / e_cnt;
    if (e_cnt == 0)
      chk(edges == 1, "R9 empty done timing", edges, 1);
    else
      chk(edges == TW + 1, "R8 done timing", edges, TW + 1);
    chk(int'(average) == exp_avg, (e_cnt == 0) ? "R9 empty average" : "R8 average",
        int'(average), exp_avg);
    chk(average <= peak, "R10 average within peak", int'(average), int'(peak));
    chk(int'(peak) == e_peak, "R7 peak kept over busy start", int'(peak), e_peak);
    chk(int'(total) == e_total, "R7 total kept over busy start", int'(total), e_total);
    cyc();
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(int'(average) == exp_avg, "R8 average held", int'(average), exp_avg);
    chk(in_ready == 1'b1, "R4 ready back", int'(in_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int idx, w, wl;
    rst_n = 1'b0; in_valid = 1'b0; in_pattern = '0;
    win_start = 1'b0; win_end = 1'b0;
    e_peak = 0; e_total = 0; e_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(metric_valid == 1'b0 && done == 1'b0, "R1 strobes", int'({metric_valid, done}), 0);
    chk(metric == '0 && peak == '0, "R1 metric/peak", int'(metric) + int'(peak), 0);
    chk(total == '0 && average == '0, "R1 total/average", int'(total) + int'(average), 0);
    rst_n = 1'b1;
    cyc();

    // empty window
    open_window();
    close_window();

    // every pattern, grouped into windows of growing length
    idx = 0; w = 0;
    while (idx < (1 << L)) begin
      wl = (w % 15) + 1;
      open_window();
      for (int k = 0; k < wl && idx < (1 << L); k++) begin
        send(idx);
        idx++;
        if (k % 3 == 2) begin
          cyc();
          chk(metric_valid == 1'b0, "R3 no metric on idle", int'(metric_valid), 0);
        end
      end
      cyc();
      chk(int'(peak) == e_peak, "R5 peak", int'(peak), e_peak);
      chk(int'(total) == e_total, "R6 total", int'(total), e_total);
      close_window();
      w++;
    end

    // clear wins over a metric folded on the same edge
    open_window();
    send(6'b010101);
    win_start = 1'b1;
    cyc();
    win_start = 1'b0;
    e_peak = 0; e_total = 0; e_cnt = 0;
    chk(total == '0, "R7 clear beats fold (total)", int'(total), 0);
    chk(peak == '0, "R7 clear beats fold (peak)", int'(peak), 0);
    send(6'b000011);
    send(6'b111111);
    cyc();
    chk(int'(total) == e_total, "R6 total after clear", int'(total), e_total);
    close_window();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule